// File: doc/BRIEF.md
# Concealing I2S Audio Output Stage

This block sits behind a digital audio interface receiver. It takes decoded stereo samples and sends them out as a standard I2S stream. Each sample pair comes in on a one-cycle strobe, together with per-frame flags for validity, parity error, biphase violation and block start. Each outgoing stereo frame takes its content from the newest sample held in a pending register. The controller picks between three sources when the frame begins: the pending pair as received, a stored copy of the last pair that arrived without faults, or silence.

Silence comes from two causes. The first is an explicit mute, from a pin or a register bit. The second is loss of PLL lock. An unlock mute stays on after lock returns, until one complete block of frames has arrived without a parity, biphase or lock error. The word-length setting keeps the top 24, 20, 18 or 16 bits of each output word and clears the rest. The serial clock, word select and data are produced from the system clock, which must be fast enough to drive the slots.

Top module: `i2s_conceal_out`

## Requirements
- R1: One SCK period lasts 2*SCK_HALF clock cycles. Each stereo frame has 64 SCK periods. WS is low for slots 0-31 (left) and high for slots 32-63 (right). WS and SD change only when SCK falls.
- R2: Within each 32-slot channel half, slot 0 and slots 25-31 carry 0. Slots 1 to 24 carry the 24-bit word MSB first, so data starts one SCK after each WS transition.
- R3: wlSel is sampled at the start of each frame. Code 0 keeps 24 bits, 1 keeps 20, 2 keeps 18 and 3 keeps 16. The lower bits that are dropped are output as 0.
- R4: A pair strobed in without errors during frame k goes out unchanged in frame k+1.
- R5: When the frame's validity flag is set, invalid is high for the whole output frame that carries it, and the data is unchanged. invalid rises only at a frame start.
- R6: A frame with the parity flag set makes both channels repeat the last pair that arrived without a parity or biphase flag. invalid follows that frame's validity flag.
- R7: A frame with the biphase flag set is concealed in the same way as R6.
- R8: pllLock is sampled at every frame start (WS falling). If it is low, both channels output 0 and invalid is low for that frame.
- R9: unlock equals the inverse of pllLock, delayed by one clock cycle.
- R10: After an unlock mute, output resumes only after BLOCK_LEN consecutive error-free frames have arrived, the first of them carrying the block-start flag. Any parity, biphase or lock error restarts this count. The release takes effect at the next frame start.
- R11: If mutePin or muteReg is high at a frame start, that frame outputs 0 with invalid low, whatever the validity flag says. Raising the mute during a frame leaves that frame unchanged.
- R12: When the mute command drops, normal output resumes at the next frame start.
- R13: After reset, sck=0, ws=1, sd=0, invalid=0 and unlock=0. The stored hold pair is zero, so the first frame is silent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleStb | input | 1 | One-cycle strobe for a new stereo pair |
| sampleLeft | input | SAMPLE_W | Left-channel sample |
| sampleRight | input | SAMPLE_W | Right-channel sample |
| flagValid | input | 1 | Validity flag of the frame |
| flagParity | input | 1 | Parity error on the frame |
| flagBiphase | input | 1 | Biphase violation (not a preamble) on the frame |
| flagBlockStart | input | 1 | Frame is the first of a block |
| pllLock | input | 1 | Receiver PLL in lock |
| mutePin | input | 1 | External mute request |
| muteReg | input | 1 | Register mute request |
| wlSel | input | 2 | Word-length code |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, low for left |
| sd | output | 1 | Serial data |
| invalid | output | 1 | Frame-aligned validity indication |
| unlock | output | 1 | Lock-loss indication |

## Verification
The bench builds the block with SCK_HALF=2, which gives 256 clock cycles per stereo frame, and BLOCK_LEN=8. With a block only eight frames long, a run of about thirty frames can cover the whole unlock sequence: the mute, a release attempt that a parity error in the middle of the block cancels, and the later release after a clean block. The same run covers the hold path before and after the mute, every word-length code, and both mute sources, including a mute raised and then cleared partway through a frame.

// File: rtl/i2s_conceal_pkg.sv
package i2s_conceal_pkg;
  // Strobes from the controller to the datapath
  typedef struct packed {
    logic       tick;        // a new SCK slot begins
    logic       frameStart;  // slot 0 of a stereo frame begins
    logic [5:0] nextSlot;    // slot number that starts on this tick
    logic       zeroOut;     // load silence for this frame
    logic       useHold;     // load the stored good pair
  } ctlStrobe_t;
endpackage

// File: rtl/i2s_conceal_ctrl.sv
module i2s_conceal_ctrl
  import i2s_conceal_pkg::*;
#(
  parameter int SCK_HALF  = 2,
  parameter int BLOCK_LEN = 192
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pllLock,
  input  logic       mutePin,
  input  logic       muteReg,
  input  logic       sampleStb,
  input  logic       flagParity,
  input  logic       flagBiphase,
  input  logic       flagBlockStart,
  input  logic       pendErr,
  output logic       sck,
  output logic       ws,
  output logic       unlock,
  output ctlStrobe_t stb
);
  localparam int DIV   = 2 * SCK_HALF;
  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int CNT_W = $clog2(BLOCK_LEN + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [DIV_W-1:0] SCK_RISE = DIV_W'(SCK_HALF - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BLOCK_LEN);

  logic [DIV_W-1:0] divCnt;
  logic [5:0]       slot;
  logic [5:0]       slotNext;
  logic             tick;
  logic             frameStart;
  logic             unlockMute;
  logic             unlockNext;
  logic             armed;
  logic [CNT_W-1:0] cleanCnt;
  logic             blockClean;
  logic             frameErr;

  always_comb begin
    tick       = (divCnt == DIV_LAST);
    slotNext   = slot + 6'd1;
    frameStart = tick && (slot == 6'd63);
    blockClean = armed && (cleanCnt == CNT_FULL);
    unlockNext = !pllLock || (unlockMute && !blockClean);
    frameErr   = flagParity || flagBiphase || !pllLock;
    stb.tick       = tick;
    stb.frameStart = frameStart;
    stb.nextSlot   = slotNext;
    stb.zeroOut    = unlockNext || mutePin || muteReg;
    stb.useHold    = pendErr;
  end

  // bit clock, slot counter and word select
  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
      slot   <= 6'd63;
      sck    <= 1'b0;
      ws     <= 1'b1;
      unlock <= 1'b0;
    end else begin
      unlock <= !pllLock;
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      if (divCnt == SCK_RISE) sck <= 1'b1;
      if (tick) begin
        sck  <= 1'b0;
        slot <= slotNext;
        ws   <= slotNext[5];
      end
    end
  end

  // unlock mute and clean-block release counter
  always_ff @(posedge clk) begin
    if (rst) begin
      unlockMute <= 1'b0;
      armed      <= 1'b0;
      cleanCnt   <= '0;
    end else begin
      if (frameStart) unlockMute <= unlockNext;
      if (frameStart && !pllLock) begin
        armed    <= 1'b0;
        cleanCnt <= '0;
      end else if (sampleStb) begin
        if (frameErr) begin
          armed    <= 1'b0;
          cleanCnt <= '0;
        end else if (flagBlockStart) begin
          armed    <= 1'b1;
          cleanCnt <= CNT_W'(1);
        end else if (armed && (cleanCnt != CNT_FULL)) begin
          cleanCnt <= cleanCnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/i2s_conceal_dp.sv
module i2s_conceal_dp
  import i2s_conceal_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  ctlStrobe_t          stb,
  input  logic                sampleStb,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  logic                flagValid,
  input  logic                flagParity,
  input  logic                flagBiphase,
  input  logic [1:0]          wlSel,
  output logic                sd,
  output logic                invalid,
  output logic                pendErr
);
  localparam int IDX_W = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] chIn  [2];
  logic [SAMPLE_W-1:0] pendW [2];
  logic [SAMPLE_W-1:0] holdW [2];
  logic [SAMPLE_W-1:0] outW  [2];
  logic [SAMPLE_W-1:0] keep;
  logic                pendValid;
  logic [SAMPLE_W-1:0] curWord;
  logic [4:0]          pos;
  logic                sdNext;

  function automatic logic [SAMPLE_W-1:0] keepMask(input logic [1:0] sel);
    logic [SAMPLE_W-1:0] ones;
    ones = '1;
    case (sel)
      2'd0:    return ones;
      2'd1:    return ones << 4;
      2'd2:    return ones << 6;
      default: return ones << 8;
    endcase
  endfunction

  assign chIn[0] = sampleLeft;
  assign chIn[1] = sampleRight;
  assign keep    = keepMask(wlSel);

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        pendW[ch] <= '0;
        holdW[ch] <= '0;
        outW[ch]  <= '0;
      end else begin
        if (sampleStb) pendW[ch] <= chIn[ch];
        if (stb.frameStart) begin
          if (!pendErr) holdW[ch] <= pendW[ch];
          if (stb.zeroOut)      outW[ch] <= '0;
          else if (stb.useHold) outW[ch] <= holdW[ch] & keep;
          else                  outW[ch] <= pendW[ch] & keep;
        end
      end
    end
  end

  always_comb begin
    pos     = stb.nextSlot[4:0];
    curWord = outW[stb.nextSlot[5]];
    sdNext  = 1'b0;
    if (pos != 5'd0 && int'(pos) <= SAMPLE_W)
      sdNext = curWord[IDX_W'(SAMPLE_W - int'(pos))];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendValid <= 1'b0;
      pendErr   <= 1'b0;
      invalid   <= 1'b0;
      sd        <= 1'b0;
    end else begin
      if (sampleStb) begin
        pendValid <= flagValid;
        pendErr   <= flagParity || flagBiphase;
      end
      if (stb.frameStart) invalid <= !stb.zeroOut && pendValid;
      if (stb.tick) sd <= sdNext;
    end
  end
endmodule

// File: rtl/i2s_conceal_out.sv
module i2s_conceal_out
  import i2s_conceal_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SCK_HALF  = 2,
  parameter int BLOCK_LEN = 192
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleStb,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  logic                flagValid,
  input  logic                flagParity,
  input  logic                flagBiphase,
  input  logic                flagBlockStart,
  input  logic                pllLock,
  input  logic                mutePin,
  input  logic                muteReg,
  input  logic [1:0]          wlSel,
  output logic                sck,
  output logic                ws,
  output logic                sd,
  output logic                invalid,
  output logic                unlock
);
  ctlStrobe_t ctlBus;
  logic       pendErr;

  i2s_conceal_ctrl #(.SCK_HALF(SCK_HALF), .BLOCK_LEN(BLOCK_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .pllLock(pllLock), .mutePin(mutePin),
    .muteReg(muteReg), .sampleStb(sampleStb), .flagParity(flagParity),
    .flagBiphase(flagBiphase), .flagBlockStart(flagBlockStart),
    .pendErr(pendErr), .sck(sck), .ws(ws), .unlock(unlock), .stb(ctlBus)
  );

  i2s_conceal_dp #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rst(rst), .stb(ctlBus), .sampleStb(sampleStb),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .flagValid(flagValid), .flagParity(flagParity),
    .flagBiphase(flagBiphase), .wlSel(wlSel), .sd(sd),
    .invalid(invalid), .pendErr(pendErr)
  );
endmodule

// File: rtl/i2s_conceal_chk.sv
module i2s_conceal_chk (
  input logic clk,
  input logic rst,
  input logic sck,
  input logic ws,
  input logic sd,
  input logic invalid,
  input logic unlock,
  input logic pllLock,
  input logic mutePin,
  input logic muteReg,
  input logic frameStart
);
  // R1
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ws) |-> $fell(sck));
  // R1
  sd_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd) |-> $fell(sck));
  // R2
  slot0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ws) |-> !sd);
  // R5
  inv_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(invalid) |-> $fell(ws));
  // R8
  lock_mute_chk: assert property (@(posedge clk) disable iff (rst)
    (frameStart && !pllLock) |=> !invalid);
  // R11
  cmd_mute_chk: assert property (@(posedge clk) disable iff (rst)
    (frameStart && (mutePin || muteReg)) |=> !invalid);
  // R9
  unlock_set_chk: assert property (@(posedge clk) disable iff (rst)
    !pllLock |=> unlock);
  // R9
  unlock_clr_chk: assert property (@(posedge clk) disable iff (rst)
    pllLock |=> !unlock);
endmodule

bind i2s_conceal_out i2s_conceal_chk u_chk (
  .clk(clk), .rst(rst), .sck(sck), .ws(ws), .sd(sd), .invalid(invalid),
  .unlock(unlock), .pllLock(pllLock), .mutePin(mutePin), .muteReg(muteReg),
  .frameStart(ctlBus.frameStart)
);

// File: tb/test_i2s_conceal_out.sv
module test_i2s_conceal_out;
  localparam int CLK_PERIOD = 10;
  localparam int SW   = 24;
  localparam int HALF = 2;
  localparam int BLK  = 8;
  localparam int DIV  = 2 * HALF;
  localparam int FRAME_CYC = 64 * DIV;

  logic clk = 0;
  logic rst = 1;
  logic sampleStb = 0;
  logic [SW-1:0] sampleLeft = '0, sampleRight = '0;
  logic flagValid = 0, flagParity = 0, flagBiphase = 0, flagBlockStart = 0;
  logic pllLock = 1, mutePin = 0, muteReg = 0;
  logic [1:0] wlSel = 0;
  logic sck, ws, sd, invalid, unlock;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_conceal_out #(.SAMPLE_W(SW), .SCK_HALF(HALF), .BLOCK_LEN(BLK)) i_i2s_conceal_out (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .sampleLeft(sampleLeft),
    .sampleRight(sampleRight), .flagValid(flagValid), .flagParity(flagParity),
    .flagBiphase(flagBiphase), .flagBlockStart(flagBlockStart),
    .pllLock(pllLock), .mutePin(mutePin), .muteReg(muteReg), .wlSel(wlSel),
    .sck(sck), .ws(ws), .sd(sd), .invalid(invalid), .unlock(unlock)
  );

  function automatic logic [SW-1:0] sL(input int f);
    return {4'h9, 8'(f), 12'hABF};
  endfunction
  function automatic logic [SW-1:0] sR(input int f);
    return {4'h6, 8'(f), 12'h5F7};
  endfunction
  function automatic logic [SW-1:0] lenMask(input logic [1:0] c);
    int bits;
    bits = (c == 0) ? 24 : (c == 1) ? 20 : (c == 2) ? 18 : 16;
    return ~((24'd1 << (SW - bits)) - 24'd1);
  endfunction

  task automatic check(input string tag, input logic [SW-1:0] got, input logic [SW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit modelOn = 0;
  int n = 0;
  logic [SW-1:0] pL, pR, hL, hR, cL, cR;
  logic pV, pE, cInv, mUnl, expUnl;
  int blkCnt = -1;

  always @(posedge clk) begin
    if (rst) begin
      modelOn = 1; n = 0;
      pL = 0; pR = 0; hL = 0; hR = 0; cL = 0; cR = 0;
      pV = 0; pE = 0; cInv = 0; mUnl = 0; expUnl = 0; blkCnt = -1;
    end else begin
      bit lockCleared;
      lockCleared = 0;
      n++;
      if (n % DIV == 0 && ((n / DIV) - 1) % 64 == 0) begin
        bit muteU;
        muteU = !pllLock || (mUnl && blkCnt != BLK);
        mUnl = muteU;
        if (muteU || mutePin || muteReg) begin
          cL = 0; cR = 0; cInv = 0;
        end else if (pE) begin
          cL = hL & lenMask(wlSel); cR = hR & lenMask(wlSel); cInv = pV;
        end else begin
          cL = pL & lenMask(wlSel); cR = pR & lenMask(wlSel); cInv = pV;
        end
        if (!pE) begin hL = pL; hR = pR; end
        if (!pllLock) begin blkCnt = -1; lockCleared = 1; end
      end
      if (sampleStb) begin
        if (!lockCleared) begin
          if (flagParity || flagBiphase || !pllLock) blkCnt = -1;
          else if (flagBlockStart) blkCnt = 1;
          else if (blkCnt >= 1 && blkCnt < BLK) blkCnt++;
        end
        pL = sampleLeft; pR = sampleRight; pV = flagValid;
        pE = flagParity || flagBiphase;
      end
      expUnl = !pllLock;
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      logic eSck, eWs, eSd;
      eSck = (n % DIV) >= HALF;
      eWs = 1; eSd = 0;
      if (n >= DIV) begin
        int s, p;
        logic [SW-1:0] w;
        s = ((n / DIV) - 1) % 64;
        p = s % 32;
        eWs = (s >= 32);
        w = eWs ? cR : cL;
        if (p >= 1 && p <= SW) eSd = w[SW - p];
      end
      check("R1 sck", 24'(sck), 24'(eSck));
      check("R1 ws", 24'(ws), 24'(eWs));
      check("R2 sd", 24'(sd), 24'(eSd));
      check("R5 invalid", 24'(invalid), 24'(cInv));
      check("R9 unlock", 24'(unlock), 24'(expUnl));
    end
  end

  // ---------------- deserializer of the output stream ----------------
  logic [SW-1:0] qL[$], qR[$];
  logic qI[$];
  logic prevSck = 0, lastWs = 1, gotInv = 0, started = 0;
  logic [SW-1:0] acc = 0, gotL = 0;
  int bitCnt = 0;

  always @(negedge clk) begin
    if (!rst && sck && !prevSck) begin
      if (ws != lastWs) begin
        if (ws) begin
          gotL = acc; gotInv = invalid;
        end else begin
          if (started) begin qL.push_back(gotL); qR.push_back(acc); qI.push_back(gotInv); end
          started = 1;
        end
        lastWs = ws; acc = 0; bitCnt = 0;
      end else begin
        bitCnt++;
        if (bitCnt <= SW) acc = {acc[SW-2:0], sd};
      end
    end
    prevSck = sck;
  end

  task automatic chkFrame(input string tag, input int k, input logic [SW-1:0] eL,
                          input logic [SW-1:0] eR, input logic eI);
    if (k >= qL.size()) begin
      checks++; errors++;
      $display("FAIL %s: frame %0d missing, got %0d frames expected more", tag, k, qL.size());
    end else begin
      check({tag, " left"}, qL[k], eL);
      check({tag, " right"}, qR[k], eR);
      check({tag, " invalid"}, 24'(qI[k]), 24'(eI));
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 reset sck", 24'(sck), 24'd0);
    check("R13 reset ws", 24'(ws), 24'd1);
    check("R13 reset sd/invalid/unlock", 24'({sd, invalid, unlock}), 24'd0);
    rst = 0;
    repeat (44) @(negedge clk);
    for (int f = 0; f < 30; f++) begin
      sampleLeft = sL(f); sampleRight = sR(f);
      flagValid = (f == 1 || f == 7 || f == 8 || f == 10);
      flagParity = (f == 2 || f == 14 || f == 28);
      flagBiphase = (f == 3);
      flagBlockStart = (f == 12 || f == 20);
      wlSel = (f == 4) ? 2'd1 : (f == 5) ? 2'd2 : (f == 6) ? 2'd3 : 2'd0;
      mutePin = (f == 7);
      muteReg = (f == 8);
      if (f == 10) pllLock = 0;
      if (f == 11) pllLock = 1;
      sampleStb = 1;
      @(negedge clk);
      sampleStb = 0;
      repeat (FRAME_CYC - 1) @(negedge clk);
    end
    repeat (3 * FRAME_CYC) @(negedge clk);

    chkFrame("R13 first frame silent", 0, 0, 0, 0);
    chkFrame("R4 clean pass", 1, sL(0), sR(0), 0);
    chkFrame("R5 validity", 2, sL(1), sR(1), 1);
    chkFrame("R6 parity hold", 3, sL(1), sR(1), 0);
    chkFrame("R7 biphase hold", 4, sL(1), sR(1), 0);
    chkFrame("R3 20 bits", 5, sL(4) & 24'hFFFFF0, sR(4) & 24'hFFFFF0, 0);
    chkFrame("R3 18 bits", 6, sL(5) & 24'hFFFFC0, sR(5) & 24'hFFFFC0, 0);
    chkFrame("R3 16 bits R11 mid-frame", 7, sL(6) & 24'hFFFF00, sR(6) & 24'hFFFF00, 0);
    chkFrame("R11 pin mute", 8, 0, 0, 0);
    chkFrame("R11 reg mute", 9, 0, 0, 0);
    chkFrame("R12 mute release", 10, sL(9), sR(9), 0);
    chkFrame("R8 unlock mute", 11, 0, 0, 0);
    chkFrame("R10 error restarts count", 20, 0, 0, 0);
    chkFrame("R10 still muted", 27, 0, 0, 0);
    chkFrame("R10 release", 28, sL(27), sR(27), 0);
    chkFrame("R6 hold after mute", 29, sL(27), sR(27), 0);
    chkFrame("R4 clean after hold", 30, sL(29), sR(29), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule